// File: doc/BRIEF.md
# Programmable Dual Down-Counting Timer

This block holds two independent 32-bit down-counters that share one word-addressed register window. A host writes a reload value and a control word into a channel. When the channel is enabled it counts down once per prescaled tick. When the count expires it raises a status flag and, if the channel allows it, a level interrupt. The channel then stops, restarts from its stored reload value, or restarts from all-ones, depending on its control word.

Each channel has its own tick-enable input, so the count rate is set outside the block and then divided by 1, 16 or 256 inside it. The counter width can be 16 or 32 bits and is chosen at run time. A second reload register lets software change the next period without disturbing the count in progress. The bus is a plain single-cycle word interface. Read data is combinational from the address, and a write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high.

Top module: `dual_down_timer`

## Requirements
- R1: After reset, for each channel: control reads 0x20, both reload views read 0xFFFFFFFF, the current value reads 0, raw and masked status read 0, and `irq` is low.
- R2: `bus_addr[3]` selects the channel. `bus_addr[2:0]` selects the register: 0 reload (restarting), 1 current value, 2 control, 3 interrupt clear (reads 0), 4 raw status (bit 0), 5 masked status (bit 0), 6 reload (background), 7 unused (reads 0, writes ignored).
- R3: Control bits 3:2 pick the prescale divisor: 0 gives one count per tick, 1 gives one per 16 ticks, and 2 or 3 give one per 256 ticks. The divider restarts whenever the channel restarts or is disabled.
- R4: Control bit 1 set counts all 32 bits. Clear, only the low 16 bits of any value loaded into the counter are kept. A count started from N expires on the N-th count step, and N of 0 expires on the first step.
- R5: A write to register 0 stores the reload value. If the channel is enabled, the same edge also restarts the count from it.
- R6: A write to register 6 stores the reload value and leaves the count in progress untouched.
- R7: Control bit 7 enables the channel. A control write that changes it from 0 to 1 restarts the count from the stored reload value. Any other control write does not restart. Bit 4 always reads 0.
- R8: Writes to the current-value register have no effect.
- R9: On expiry the raw status sets. Masked status always equals raw status AND control bit 5, and `irq` follows masked status.
- R10: On expiry, control bit 0 set stops the channel at 0 until the next restart. Otherwise, control bit 6 clear reloads all-ones and bit 6 set reloads the stored reload value, both cut to the counter size.
- R11: Any write to register 3 clears raw status. If an expiry happens on the same edge, the expiry wins.
- R12: A disabled channel holds its current value and cannot expire.
- R13: Traffic to one channel leaves the other channel's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 4 | Word address: bit 3 channel, bits 2:0 register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_en | input | 2 | Count-rate enable, one bit per channel |
| irq | output | 2 | Level interrupt, one bit per channel |

## Verification
The embedded properties check, on every cycle, rules that hold at every edge:
- a disabled channel keeps its count;
- a background reload or a current-value write never moves the count;
- a clear removes the raw flag unless an expiry coincides;
- raw status only rises after a count step;
- a halted one-shot channel stays at zero;
- a 16-bit restart leaves the upper half empty;
- the divider returns to zero after each step.

Only the bench's scenarios can show the exact period for each divisor, which reload value each mode picks, the reset values and the channel decode. For those it compares every read and both interrupt lines against a cycle-level reference model, both under directed sequences and under random traffic.

// File: rtl/dtmr_pkg.sv
// Package: shared register indices and the control-word layout.
// Assumes one 32-bit word per register and eight register slots per channel.
package dtmr_pkg;

    localparam int REG_IDX_W = 3;

    typedef enum logic [REG_IDX_W-1:0] {
        REG_RELOAD = 3'd0,
        REG_VALUE  = 3'd1,
        REG_CTRL   = 3'd2,
        REG_ACK    = 3'd3,
        REG_RAW    = 3'd4,
        REG_MASKED = 3'd5,
        REG_BGLOAD = 3'd6
    } reg_idx_e;

    // Control word, most significant field first (bit 7 down to bit 0).
    typedef struct packed {
        logic       run;       // bit 7: channel enable
        logic       periodic;  // bit 6: reload from stored value (1) or all-ones (0)
        logic       irq_en;    // bit 5: interrupt enable
        logic       rsvd;      // bit 4: always zero
        logic [1:0] psc;       // bits 3:2: prescale exponent
        logic       wide;      // bit 1: 32-bit counter when set
        logic       single;    // bit 0: one-shot
    } ctrl_t;

    localparam logic [7:0] CTRL_RESET = 8'h20;
    localparam logic [7:0] CTRL_WMASK = 8'hEF;

endpackage

// File: rtl/dtmr_prescale.sv
// Module: tick divider for one timer channel.
// Produces a one-cycle count step every 16**sel_i enabled ticks; exponents
// above the largest supported value behave as the largest one.
// Assumes clear_i is high whenever the channel is disabled or restarting.
module dtmr_prescale #(
    parameter int SEL_W     = 2,
    parameter int STEP_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             tick_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             strobe_o
);
    localparam int MAX_EXP = (1 << SEL_W) - 2;
    localparam int CNT_W   = STEP_LOG2 * MAX_EXP;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic [CNT_W:0]   pow;
    int               exp_v;

    // Terminal count for the selected divisor.
    always_comb begin
        exp_v = (int'(sel_i) > MAX_EXP) ? MAX_EXP : int'(sel_i);
        pow   = (CNT_W+1)'(1) << (STEP_LOG2 * exp_v);
        limit = pow[CNT_W-1:0] - CNT_W'(1);
    end

    assign strobe_o = tick_i && !clear_i && (cnt_q == limit);

    // Tick counter, cleared while idle or on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= (cnt_q == limit) ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // R3: a count step always returns the divider to zero.
    a_r3_wrap_after_step: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> (cnt_q == '0));

    // R3: a clear leaves the divider at zero on the next cycle.
    a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0));

endmodule

// File: rtl/dtmr_channel.sv
// Module: one down-counting timer channel with its register file.
// Holds the reload value, control word, counter and raw flag, and decodes
// writes and reads of its eight register slots.
// Assumes wr_i lasts one cycle per access and reg_i is valid with it.
module dtmr_channel
    import dtmr_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int HALF_W    = 16,
    parameter int SEL_W     = 2,
    parameter int STEP_LOG2 = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 wr_i,
    input  logic [REG_IDX_W-1:0] reg_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    rdata_o,
    output logic                 irq_o
);
    logic [DATA_W-1:0] load_q, cur_q, cur_d;
    ctrl_t             ctrl_q, ctrl_new;
    logic              raw_q, halt_q, halt_d;
    logic              wr_load, wr_ctrl, wr_ack, wr_bg, wr_val;
    logic              restart, restart_wide, strobe, hit, fire;
    logic [DATA_W-1:0] restart_src;

    // Cut a value to the active counter size.
    function automatic logic [DATA_W-1:0] fit(input logic [DATA_W-1:0] v, input logic wide);
        return wide ? v : {{(DATA_W-HALF_W){1'b0}}, v[HALF_W-1:0]};
    endfunction

    // Write decode for each register slot.
    always_comb begin
        wr_load  = wr_i && (reg_i == REG_RELOAD);
        wr_val   = wr_i && (reg_i == REG_VALUE);
        wr_ctrl  = wr_i && (reg_i == REG_CTRL);
        wr_ack   = wr_i && (reg_i == REG_ACK);
        wr_bg    = wr_i && (reg_i == REG_BGLOAD);
        ctrl_new = ctrl_t'(wdata_i[7:0] & CTRL_WMASK);
    end

    // Restart request: reload write while enabled, or enable rising.
    always_comb begin
        restart      = (wr_load && ctrl_q.run) || (wr_ctrl && !ctrl_q.run && ctrl_new.run);
        restart_src  = wr_load ? wdata_i : load_q;
        restart_wide = wr_ctrl ? ctrl_new.wide : ctrl_q.wide;
    end

    dtmr_prescale #(
        .SEL_W     (SEL_W),
        .STEP_LOG2 (STEP_LOG2)
    ) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (!ctrl_q.run || restart),
        .tick_i   (tick_i),
        .sel_i    (ctrl_q.psc),
        .strobe_o (strobe)
    );

    assign hit  = strobe && !halt_q;
    assign fire = hit && (cur_q[DATA_W-1:1] == '0);

    // Next counter value: restart, expiry reload, or decrement.
    always_comb begin
        cur_d  = cur_q;
        halt_d = halt_q;
        if (restart) begin
            cur_d  = fit(restart_src, restart_wide);
            halt_d = 1'b0;
        end else if (fire) begin
            if (ctrl_q.single) begin
                cur_d  = '0;
                halt_d = 1'b1;
            end else if (ctrl_q.periodic) begin
                cur_d = fit(load_q, ctrl_q.wide);
            end else begin
                cur_d = fit('1, ctrl_q.wide);
            end
        end else if (hit) begin
            cur_d = cur_q - DATA_W'(1);
        end
    end

    // Counter and one-shot halt state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            halt_q <= 1'b0;
        end else begin
            cur_q  <= cur_d;
            halt_q <= halt_d;
        end
    end

    // Stored reload value and control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= '1;
            ctrl_q <= ctrl_t'(CTRL_RESET);
        end else begin
            if (wr_load || wr_bg) load_q <= wdata_i;
            if (wr_ctrl)          ctrl_q <= ctrl_new;
        end
    end

    // Raw expiry flag: set on expiry, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)      raw_q <= 1'b0;
        else if (fire)   raw_q <= 1'b1;
        else if (wr_ack) raw_q <= 1'b0;
    end

    assign irq_o = raw_q && ctrl_q.irq_en;

    // Read mux over the register slots.
    always_comb begin
        case (reg_i)
            REG_RELOAD, REG_BGLOAD: rdata_o = load_q;
            REG_VALUE:              rdata_o = cur_q;
            REG_CTRL:               rdata_o = DATA_W'(ctrl_q);
            REG_RAW:                rdata_o = DATA_W'(raw_q);
            REG_MASKED:             rdata_o = DATA_W'(irq_o);
            default:                rdata_o = '0;
        endcase
    end

    // R12: a disabled channel that is not restarted keeps its count.
    a_r12_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.run && !restart) |=> $stable(cur_q));

    // R6: a background reload write does not move the count.
    a_r6_bg_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_bg && !hit) |=> $stable(cur_q));

    // R8: a current-value write does not move the count.
    a_r8_value_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_val && !hit) |=> $stable(cur_q));

    // R11: an acknowledge without a coinciding expiry drops the raw flag.
    a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack && !fire) |=> !raw_q);

    // R9: the raw flag only rises after a count step.
    a_r9_raw_after_step: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_q) |-> $past(hit));

    // R10: a halted one-shot channel stays at zero until restarted.
    a_r10_single_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_q && !restart) |=> (halt_q && cur_q == '0));

    // R4: a 16-bit restart leaves the upper half clear.
    a_r4_half_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !restart_wide) |=> (cur_q[DATA_W-1:HALF_W] == '0));

endmodule

// File: rtl/dual_down_timer.sv
// Module: top of the dual down-counting timer.
// Splits the word address into channel and register index, fans writes out
// to the selected channel and muxes its read data back.
// Assumes NUM_CH equals 2**(ADDR_W - REG_IDX_W).
module dual_down_timer
    import dtmr_pkg::*;
#(
    parameter int NUM_CH    = 2,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int HALF_W    = 16,
    parameter int SEL_W     = 2,
    parameter int STEP_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] tick_en,
    output logic [NUM_CH-1:0] irq
);
    localparam int CH_SEL_W = ADDR_W - REG_IDX_W;

    logic [CH_SEL_W-1:0]  ch_idx;
    logic [REG_IDX_W-1:0] reg_idx;
    logic [DATA_W-1:0]    ch_rdata [NUM_CH];

    assign ch_idx  = bus_addr[ADDR_W-1:REG_IDX_W];
    assign reg_idx = bus_addr[REG_IDX_W-1:0];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dtmr_channel #(
            .DATA_W    (DATA_W),
            .HALF_W    (HALF_W),
            .SEL_W     (SEL_W),
            .STEP_LOG2 (STEP_LOG2)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick_en[c]),
            .wr_i    (bus_sel && bus_wr && (ch_idx == CH_SEL_W'(c))),
            .reg_i   (reg_idx),
            .wdata_i (bus_wdata),
            .rdata_o (ch_rdata[c]),
            .irq_o   (irq[c])
        );
    end

    // Read data of the addressed channel.
    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_idx == CH_SEL_W'(c)) bus_rdata = ch_rdata[c];
        end
    end

endmodule

// File: tb/dual_down_timer_tb_top.sv
// Bench: directed corner cases and seeded random traffic. Each cycle the
// bench compares read data and interrupts against a cycle-level model.
module dual_down_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_sel = 1'b0, b_wr = 1'b0;
    logic [3:0]  b_addr = '0;
    logic [31:0] b_wd = '0;
    logic [1:0]  b_tick = '0;
    logic [31:0] rdata;
    logic [1:0]  irq;
    int          total = 0, bad = 0;

    always #4 clk = ~clk;

    dual_down_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(b_sel), .bus_wr(b_wr),
        .bus_addr(b_addr), .bus_wdata(b_wd), .bus_rdata(rdata),
        .tick_en(b_tick), .irq(irq)
    );

    // Reference model state.
    logic [31:0] m_load [2];
    logic [31:0] m_cur  [2];
    logic [7:0]  m_ctl  [2];
    logic [7:0]  m_pc   [2];
    logic        m_raw  [2];
    logic        m_halt [2];

    function automatic logic [31:0] fit(input logic [31:0] v, input logic wide);
        return wide ? v : {16'h0, v[15:0]};
    endfunction

    function automatic logic [7:0] plim(input logic [7:0] ctl);
        case (ctl[3:2])
            2'd0:    return 8'd0;
            2'd1:    return 8'd15;
            default: return 8'd255;
        endcase
    endfunction

    function automatic logic [31:0] model_read(input logic [3:0] a);
        int c = int'(a[3]);
        case (a[2:0])
            3'd0, 3'd6: return m_load[c];
            3'd1:       return m_cur[c];
            3'd2:       return {24'h0, m_ctl[c]};
            3'd4:       return {31'h0, m_raw[c]};
            3'd5:       return {31'h0, m_raw[c] & m_ctl[c][5]};
            default:    return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] off);
        case (off)
            3'd0, 3'd6: return "R5";
            3'd1:       return "R4";
            3'd2:       return "R7";
            3'd4, 3'd5: return "R9";
            default:    return "R2";
        endcase
    endfunction

    // One model step per clock edge from the driven inputs.
    always @(posedge clk) begin
        for (int c = 0; c < 2; c++) begin
            if (!rst_n) begin
                m_load[c] = 32'hFFFF_FFFF; m_cur[c] = 0; m_ctl[c] = 8'h20;
                m_pc[c] = 0; m_raw[c] = 0; m_halt[c] = 0;
            end else begin
                logic       wr, run, rs, strobe, hit, fire;
                logic [2:0] off;
                logic [7:0] nctl;
                wr   = b_sel && b_wr && (int'(b_addr[3]) == c);
                off  = b_addr[2:0];
                run  = m_ctl[c][7];
                nctl = b_wd[7:0] & 8'hEF;
                rs   = wr && ((off == 0 && run) || (off == 2 && !run && nctl[7]));
                strobe = run && b_tick[c] && !rs && (m_pc[c] == plim(m_ctl[c]));
                hit  = strobe && !m_halt[c];
                fire = hit && (m_cur[c] <= 1);
                if (rs) begin
                    m_cur[c]  = fit(off == 0 ? b_wd : m_load[c], off == 2 ? nctl[1] : m_ctl[c][1]);
                    m_halt[c] = 0;
                end else if (fire) begin
                    if (m_ctl[c][0]) begin m_cur[c] = 0; m_halt[c] = 1; end
                    else if (m_ctl[c][6]) m_cur[c] = fit(m_load[c], m_ctl[c][1]);
                    else m_cur[c] = fit(32'hFFFF_FFFF, m_ctl[c][1]);
                end else if (hit) m_cur[c] = m_cur[c] - 1;
                if (!run || rs) m_pc[c] = 0;
                else if (b_tick[c]) m_pc[c] = (m_pc[c] == plim(m_ctl[c])) ? 8'd0 : m_pc[c] + 8'd1;
                if (fire) m_raw[c] = 1;
                else if (wr && off == 3) m_raw[c] = 0;
                if (wr && (off == 0 || off == 6)) m_load[c] = b_wd;
                if (wr && off == 2) m_ctl[c] = nctl;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, then compare against the model.
    task automatic step(input logic s, input logic w, input logic [3:0] a,
                        input logic [31:0] d, input logic [1:0] t);
        @(negedge clk);
        b_sel = s; b_wr = w; b_addr = a; b_wd = d; b_tick = t;
        #1;
        chk(tag_of(a[2:0]), rdata, model_read(a));
        chk("R9", {30'h0, irq}, {30'h0, m_raw[1] & m_ctl[1][5], m_raw[0] & m_ctl[0][5]});
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        step(1, 1, a, d, 2'b00);
    endtask

    task automatic expect_rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        step(0, 0, a, 0, 2'b00);
        chk(tag, rdata, exp);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 4'h0, 0, 2'b11);
    endtask

    initial begin
        #(8 * 150000);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        expect_rd(4'h2, 32'h20, "R1");
        expect_rd(4'h0, 32'hFFFF_FFFF, "R1");
        expect_rd(4'h1, 32'h0, "R1");
        expect_rd(4'h4, 32'h0, "R1");
        chk("R1", {30'h0, irq}, 32'h0);
        // R2 decode
        expect_rd(4'hE, 32'hFFFF_FFFF, "R2");
        expect_rd(4'h7, 32'h0, "R2");
        wr(4'hF, 32'hDEAD_BEEF);
        expect_rd(4'hF, 32'h0, "R2");
        // R5 reload while disabled: no restart
        wr(4'h0, 32'd5);
        expect_rd(4'h1, 32'h0, "R5");
        expect_rd(4'h0, 32'd5, "R5");
        // R7 enable rising restarts; periodic, irq enabled, 32-bit
        wr(4'h2, 32'hE2);
        expect_rd(4'h1, 32'd5, "R7");
        run(4);
        expect_rd(4'h1, 32'd1, "R4");
        expect_rd(4'h4, 32'd0, "R9");
        run(1);
        expect_rd(4'h4, 32'd1, "R9");
        expect_rd(4'h5, 32'd1, "R9");
        chk("R9", {31'h0, irq[0]}, 32'd1);
        expect_rd(4'h1, 32'd5, "R10");
        // R11 clear
        wr(4'h3, 32'h0);
        expect_rd(4'h4, 32'd0, "R11");
        chk("R11", {31'h0, irq[0]}, 32'd0);
        // R8 current-value write ignored
        wr(4'h1, 32'h1234);
        expect_rd(4'h1, 32'd5, "R8");
        // R6 background reload
        wr(4'h6, 32'd3);
        expect_rd(4'h1, 32'd5, "R6");
        expect_rd(4'h0, 32'd3, "R6");
        run(5);
        expect_rd(4'h1, 32'd3, "R6");
        // R5 reload while enabled restarts
        wr(4'h0, 32'h12345);
        expect_rd(4'h1, 32'h12345, "R5");
        wr(4'h2, 32'hE0);
        expect_rd(4'h1, 32'h12345, "R7");
        wr(4'h0, 32'h12345);
        expect_rd(4'h1, 32'h2345, "R4");
        wr(4'h3, 32'h0);
        wr(4'h2, 32'h70);
        expect_rd(4'h2, 32'h60, "R7");
        // R10 one-shot on channel 1
        wr(4'h8, 32'd2);
        wr(4'hA, 32'hA3);
        expect_rd(4'h9, 32'd2, "R13");
        run(2);
        expect_rd(4'h9, 32'd0, "R10");
        expect_rd(4'hC, 32'd1, "R10");
        chk("R9", {31'h0, irq[1]}, 32'd1);
        run(3);
        expect_rd(4'h9, 32'd0, "R10");
        expect_rd(4'h1, 32'h2345, "R12");
        expect_rd(4'h4, 32'd0, "R13");
        // R10 free-running, interrupt masked
        wr(4'hB, 32'h0);
        wr(4'hA, 32'h00);
        wr(4'h8, 32'd1);
        wr(4'hA, 32'h82);
        run(1);
        expect_rd(4'h9, 32'hFFFF_FFFF, "R10");
        expect_rd(4'hC, 32'd1, "R9");
        expect_rd(4'hD, 32'd0, "R9");
        chk("R9", {31'h0, irq[1]}, 32'd0);
        // R3 divide by 16 and by 256
        wr(4'hA, 32'h00);
        wr(4'h8, 32'd3);
        wr(4'hA, 32'hC6);
        run(15);
        expect_rd(4'h9, 32'd3, "R3");
        run(1);
        expect_rd(4'h9, 32'd2, "R3");
        wr(4'hA, 32'h00);
        wr(4'hA, 32'hCA);
        run(255);
        expect_rd(4'h9, 32'd3, "R3");
        run(1);
        expect_rd(4'h9, 32'd2, "R3");
        // R10 free-running 16-bit wraps to 0xFFFF
        wr(4'h0, 32'd1);
        wr(4'h2, 32'h80);
        run(1);
        expect_rd(4'h1, 32'h0000_FFFF, "R10");
        // Random traffic, checked against the model every cycle
        for (int i = 0; i < 5000; i++) begin
            logic [31:0] d = $urandom;
            logic [3:0]  a = 4'($urandom);
            if ($urandom % 16 < 3) begin
                if (a[2:0] == 3'd2 && d[9:8] != 2'b00) d[3:2] = 2'b00;
                if ((a[2:0] == 3'd0 || a[2:0] == 3'd6) && d[31:29] != 3'b111) d = d % 24;
                step(1, 1, a, d, 2'($urandom));
            end else begin
                step(0, 0, a, 0, 2'($urandom));
            end
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule